// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

The controller gathers 43 maskable interrupt request lines. Each line has its own enable, pending flag, active flag and 4-bit priority. From every channel that is both enabled and pending, it picks the one with the best priority. When that channel outranks the handler now running, it offers the channel to the processor core as a vector index with an entry request. The core accepts the offer with an acknowledge and reports the end of each handler with a one-cycle exit pulse.

The entry offer is a valid/ready pair: `entry_req` is valid and `entry_ack` is ready. The core applies back-pressure by holding `entry_ack` low, and the offer then stays up for as long as a winner exists. Until the offer is accepted, `entry_vec` is not held stable. It follows the current winner, so a better request that arrives late replaces the one first offered. An offer can also be withdrawn if software clears or disables the channel. Accepting an offer pushes the channel's priority onto a nesting stack. An exit pops the stack and restores the level that was interrupted. If a pending request beats the restored level, it is offered in the very next cycle, with no gap between the two handlers.

Software uses a one-cycle register port. Each write names a channel and an operation: set enable, set pending, clear pending or set priority. A read returns the channel's state combinationally. A lower priority value means higher urgency (0 is the most urgent), and the idle level ranks below every priority.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset every channel has enable, pending, active and priority at zero, and `entry_req` is low.
- R2: A register write takes effect at the clock edge. `reg_op` 0 writes the enable from `reg_wdata[0]` and 3 writes the priority from `reg_wdata[3:0]`. `reg_rdata` packs {active[6], pending[5], enable[4], priority[3:0]} for `reg_ch`. A channel number of 43 or more is ignored on write and reads as zero.
- R3: Pending is set when an `irq_i` line is high in a cycle after being low in the previous one, or by a `reg_op` 2'd1 write. A line held high does not set pending again.
- R4: A `reg_op` 2'd2 write clears pending. If a set from either source falls in the same cycle, the set wins.
- R5: A channel that is disabled still latches pending but is never offered. Only enabled and pending channels are eligible.
- R6: The offered vector is the eligible channel with the lowest priority value. Among equal values, the lowest channel number wins.
- R7: `entry_req` is high only when the winner's priority value is strictly lower than the current level. An equal priority never preempts.
- R8: While `entry_req` waits for `entry_ack`, `entry_vec` tracks the current winner, so a better late arrival replaces the first offer. In an accepted cycle the channel's pending is cleared, its active flag is set and the level becomes its priority.
- R9: `exit_i` clears the active flag of the most recently entered channel and restores the level it preempted. An exit with nothing active changes nothing.
- R10: When an exit leaves an eligible winner that beats the restored level, `entry_req` is high in the cycle right after the exit cycle (tail-chain).
- R11: Nesting holds 16 levels, one per priority value, with every level tracked and unwound in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | 43 | Interrupt request lines, edge-detected |
| reg_we | input | 1 | Register write strobe |
| reg_op | input | 2 | Write operation: 0 enable, 1 set pending, 2 clear pending, 3 priority |
| reg_ch | input | 6 | Channel addressed by a read or write |
| reg_wdata | input | 4 | Write data (enable in bit 0, priority in bits 3:0) |
| reg_rdata | output | 7 | State of channel `reg_ch` |
| entry_req | output | 1 | Entry offer valid |
| entry_vec | output | 6 | Vector index of the offered channel |
| entry_ack | input | 1 | Core accepts the offer |
| exit_i | input | 1 | Core finished the innermost handler |

## Verification
The arbiter is exercised with several patterns. A tie at equal priority checks that the lower channel number wins, and a more urgent channel raised while an offer waits checks that the vector is switched rather than latched. An equal-priority request during a running handler shows that preemption is strict and not "at least equal". Back-to-back exits with pending work behind them show the chain fires in the next cycle rather than after an idle gap. Request lines are held high, cleared during the high phase, and raised in the same cycle as a software clear, which separates edge detection from level sensing and confirms that a set wins over a clear. A full sixteen-level nest, unwound with a pending channel beneath the top, checks that each exit restores exactly the preempted level.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  typedef enum logic [1:0] {
    OP_ENABLE   = 2'd0,
    OP_PEND_SET = 2'd1,
    OP_PEND_CLR = 2'd2,
    OP_PRIO     = 2'd3
  } reg_op_e;
endpackage

// File: rtl/irq_chan_bank.sv
module irq_chan_bank
  import irq_vec_pkg::*;
#(
  parameter int N_IRQ  = 43,
  parameter int IDX_W  = 6,
  parameter int PRIO_W = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [N_IRQ-1:0]             irq_i,
  input  logic                         reg_we,
  input  logic [1:0]                   reg_op,
  input  logic [IDX_W-1:0]             reg_ch,
  input  logic [PRIO_W-1:0]            reg_wdata,
  input  logic                         take_i,
  input  logic [IDX_W-1:0]             take_idx_i,
  input  logic                         drop_i,
  input  logic [IDX_W-1:0]             drop_idx_i,
  output logic [N_IRQ-1:0]             en_o,
  output logic [N_IRQ-1:0]             pend_o,
  output logic [N_IRQ-1:0]             act_o,
  output logic [N_IRQ-1:0][PRIO_W-1:0] prio_o
);

  for (genvar g = 0; g < N_IRQ; g++) begin : g_ch
    logic line_q;
    logic hit;
    logic rise;
    logic set_p;
    logic clr_p;
    logic mine_take;
    logic mine_drop;

    assign hit       = reg_we && (reg_ch == IDX_W'(g));
    assign rise      = irq_i[g] && !line_q;
    assign set_p     = rise || (hit && reg_op == OP_PEND_SET);
    assign mine_take = take_i && (take_idx_i == IDX_W'(g));
    assign mine_drop = drop_i && (drop_idx_i == IDX_W'(g));
    assign clr_p     = mine_take || (hit && reg_op == OP_PEND_CLR);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        line_q    <= 1'b0;
        en_o[g]   <= 1'b0;
        pend_o[g] <= 1'b0;
        act_o[g]  <= 1'b0;
        prio_o[g] <= '0;
      end else begin
        line_q <= irq_i[g];
        if (hit && reg_op == OP_ENABLE) en_o[g] <= reg_wdata[0];
        if (hit && reg_op == OP_PRIO) prio_o[g] <= reg_wdata;
        // a new request outranks any clear in the same cycle
        if (set_p) pend_o[g] <= 1'b1;
        else if (clr_p) pend_o[g] <= 1'b0;
        // a re-entry of the channel being left keeps it active
        if (mine_take) act_o[g] <= 1'b1;
        else if (mine_drop) act_o[g] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N_IRQ  = 43,
  parameter int IDX_W  = 6,
  parameter int PRIO_W = 4
) (
  input  logic [N_IRQ-1:0]             elig_i,
  input  logic [N_IRQ-1:0][PRIO_W-1:0] prio_i,
  output logic                         found_o,
  output logic [IDX_W-1:0]             idx_o,
  output logic [PRIO_W-1:0]            prio_o
);

  // scan upward; strict compare keeps the lowest index on a tie
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    prio_o  = '1;
    for (int i = 0; i < N_IRQ; i++) begin
      if (elig_i[i] && (!found_o || prio_i[i] < prio_o)) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
        prio_o  = prio_i[i];
      end
    end
  end

endmodule

// File: rtl/irq_nest_stack.sv
module irq_nest_stack #(
  parameter int DEPTH  = 16,
  parameter int IDX_W  = 6,
  parameter int PRIO_W = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                push_i,
  input  logic [IDX_W-1:0]                    push_idx_i,
  input  logic [PRIO_W-1:0]                   push_prio_i,
  input  logic                                pop_i,
  output logic [PRIO_W:0]                     level_o,
  output logic [IDX_W-1:0]                    top_idx_o,
  output logic                                busy_o,
  output logic [$clog2(DEPTH+1)-1:0]          depth_o
);

  localparam int SP_W  = $clog2(DEPTH + 1);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PRIO_W-1:0] prio_mem [DEPTH];
  logic [IDX_W-1:0]  idx_mem  [DEPTH];
  logic [SP_W-1:0]   sp;
  logic [SP_W-1:0]   base;
  logic [PTR_W-1:0]  top_ptr;
  logic [PTR_W-1:0]  wr_ptr;
  logic              pop_ok;
  logic              push_ok;

  assign busy_o  = (sp != '0);
  assign pop_ok  = pop_i && busy_o;
  assign base    = sp - SP_W'(pop_ok);
  assign push_ok = push_i && (base < SP_W'(DEPTH));
  assign top_ptr = PTR_W'(sp - SP_W'(1));
  assign wr_ptr  = PTR_W'(base);
  assign depth_o = sp;

  always_ff @(posedge clk) begin
    if (!rst_n) sp <= '0;
    else        sp <= base + SP_W'(push_ok);
  end

  always_ff @(posedge clk) begin
    if (push_ok) begin
      prio_mem[wr_ptr] <= push_prio_i;
      idx_mem[wr_ptr]  <= push_idx_i;
    end
  end

  assign level_o   = busy_o ? {1'b0, prio_mem[top_ptr]} : {1'b1, {PRIO_W{1'b0}}};
  assign top_idx_o = busy_o ? idx_mem[top_ptr] : '0;

endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl #(
  parameter int N_IRQ  = 43,
  parameter int PRIO_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_IRQ-1:0]            irq_i,
  input  logic                        reg_we,
  input  logic [1:0]                  reg_op,
  input  logic [$clog2(N_IRQ)-1:0]    reg_ch,
  input  logic [PRIO_W-1:0]           reg_wdata,
  output logic [PRIO_W+2:0]           reg_rdata,
  output logic                        entry_req,
  output logic [$clog2(N_IRQ)-1:0]    entry_vec,
  input  logic                        entry_ack,
  input  logic                        exit_i
);

  localparam int IDX_W = $clog2(N_IRQ);
  localparam int DEPTH = 1 << PRIO_W;
  localparam int SP_W  = $clog2(DEPTH + 1);

  logic [N_IRQ-1:0]             ch_en;
  logic [N_IRQ-1:0]             ch_pend;
  logic [N_IRQ-1:0]             ch_act;
  logic [N_IRQ-1:0][PRIO_W-1:0] ch_prio;
  logic                         cand_found;
  logic [IDX_W-1:0]             cand_idx;
  logic [PRIO_W-1:0]            cand_prio;
  logic [PRIO_W:0]              cur_level;
  logic [IDX_W-1:0]             top_idx;
  logic                         nest_busy;
  logic [SP_W-1:0]              nest_depth;
  logic                         take;
  logic                         drop;

  irq_chan_bank #(.N_IRQ(N_IRQ), .IDX_W(IDX_W), .PRIO_W(PRIO_W)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_i      (irq_i),
    .reg_we     (reg_we),
    .reg_op     (reg_op),
    .reg_ch     (reg_ch),
    .reg_wdata  (reg_wdata),
    .take_i     (take),
    .take_idx_i (cand_idx),
    .drop_i     (drop),
    .drop_idx_i (top_idx),
    .en_o       (ch_en),
    .pend_o     (ch_pend),
    .act_o      (ch_act),
    .prio_o     (ch_prio)
  );

  irq_pick #(.N_IRQ(N_IRQ), .IDX_W(IDX_W), .PRIO_W(PRIO_W)) u_pick (
    .elig_i  (ch_en & ch_pend),
    .prio_i  (ch_prio),
    .found_o (cand_found),
    .idx_o   (cand_idx),
    .prio_o  (cand_prio)
  );

  irq_nest_stack #(.DEPTH(DEPTH), .IDX_W(IDX_W), .PRIO_W(PRIO_W)) u_nest (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (take),
    .push_idx_i  (cand_idx),
    .push_prio_i (cand_prio),
    .pop_i       (exit_i),
    .level_o     (cur_level),
    .top_idx_o   (top_idx),
    .busy_o      (nest_busy),
    .depth_o     (nest_depth)
  );

  // offer follows the live winner until the core takes it
  assign entry_req = cand_found && ({1'b0, cand_prio} < cur_level);
  assign entry_vec = cand_idx;
  assign take      = entry_req && entry_ack;
  assign drop      = exit_i && nest_busy;

  always_comb begin
    reg_rdata = '0;
    if (reg_ch < IDX_W'(N_IRQ)) begin
      reg_rdata = {ch_act[reg_ch], ch_pend[reg_ch], ch_en[reg_ch], ch_prio[reg_ch]};
    end
  end

endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk #(
  parameter int N_IRQ  = 43,
  parameter int PRIO_W = 4
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             entry_req,
  input logic [$clog2(N_IRQ)-1:0]         entry_vec,
  input logic                             entry_ack,
  input logic                             exit_i,
  input logic [N_IRQ-1:0]                 en,
  input logic [N_IRQ-1:0]                 pend,
  input logic [N_IRQ-1:0]                 act,
  input logic [N_IRQ-1:0][PRIO_W-1:0]     prio,
  input logic [PRIO_W:0]                  level,
  input logic [$clog2((1<<PRIO_W)+1)-1:0] depth
);

  localparam int DEPTH = 1 << PRIO_W;

  a_r5_offer_enabled_pending: assert property (@(posedge clk) disable iff (!rst_n)
    entry_req |-> (en[entry_vec] && pend[entry_vec]));

  a_r7_strictly_better: assert property (@(posedge clk) disable iff (!rst_n)
    entry_req |-> ({1'b0, prio[entry_vec]} < level));

  a_r8_take_sets_level: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_req && entry_ack) |=> (act[$past(entry_vec)] &&
                                   level == {1'b0, $past(prio[entry_vec])}));

  a_r9_exit_pops_one: assert property (@(posedge clk) disable iff (!rst_n)
    (exit_i && depth != '0 && !(entry_req && entry_ack)) |=> (depth == $past(depth) - 1'b1));

  a_r9_active_count_matches_nest: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(act) == int'(depth));

  a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    int'(depth) <= DEPTH);

endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .entry_req (entry_req),
  .entry_vec (entry_vec),
  .entry_ack (entry_ack),
  .exit_i    (exit_i),
  .en        (ch_en),
  .pend      (ch_pend),
  .act       (ch_act),
  .prio      (ch_prio),
  .level     (cur_level),
  .depth     (nest_depth)
);

// File: tb/tb_irq_vec_ctrl.sv
`timescale 1ns/1ps
module tb_irq_vec_ctrl;

  localparam int N = 43;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] irq_i = '0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_op = 2'd0;
  logic [5:0]  reg_ch = '0;
  logic [3:0]  reg_wdata = '0;
  logic [6:0]  reg_rdata;
  logic        entry_req;
  logic [5:0]  entry_vec;
  logic        entry_ack = 1'b0;
  logic        exit_i = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_vec_ctrl dut (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .reg_we(reg_we), .reg_op(reg_op),
    .reg_ch(reg_ch), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .entry_req(entry_req), .entry_vec(entry_vec), .entry_ack(entry_ack), .exit_i(exit_i)
  );

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(int op, int ch, int data);
    reg_we = 1'b1; reg_op = 2'(op); reg_ch = 6'(ch); reg_wdata = 4'(data);
    step();
    reg_we = 1'b0;
  endtask

  task automatic rd(int ch, output int val);
    reg_ch = 6'(ch);
    #1;
    val = int'(reg_rdata);
  endtask

  task automatic ack();
    entry_ack = 1'b1; step(); entry_ack = 1'b0;
  endtask

  task automatic leave();
    exit_i = 1'b1; step(); exit_i = 1'b0;
  endtask

  task automatic offer(string req, int vec);
    chk(req, int'(entry_req), 1);
    chk(req, int'(entry_vec), vec);
  endtask

  task automatic t_reset();
    int v;
    chk("R1 req", int'(entry_req), 0);
    rd(0, v);  chk("R1 ch0", v, 0);
    rd(42, v); chk("R1 ch42", v, 0);
  endtask

  task automatic t_regs();
    int v;
    wr(3, 5, 9); wr(0, 5, 1);
    rd(5, v); chk("R2 fields", v, 'h19);
    wr(3, 50, 7); wr(0, 50, 1);
    rd(50, v); chk("R2 out of range", v, 0);
  endtask

  task automatic t_edge();
    int v;
    irq_i[7] = 1'b1; step();
    rd(7, v); chk("R3 edge sets", v, 'h20);
    chk("R5 disabled not offered", int'(entry_req), 0);
    wr(2, 7, 0);
    rd(7, v); chk("R4 clear", v, 0);
    step();
    rd(7, v); chk("R3 level no reset", v, 0);
    irq_i[7] = 1'b0; step();
  endtask

  task automatic t_set_wins();
    int v;
    wr(1, 7, 0);
    rd(7, v); chk("R3 sw set", v, 'h20);
    wr(2, 7, 0);
    irq_i[7] = 1'b1;
    wr(2, 7, 0);
    rd(7, v); chk("R4 set beats clear", v, 'h20);
    irq_i[7] = 1'b0;
    wr(2, 7, 0);
  endtask

  task automatic t_arb();
    int v;
    wr(3, 10, 3); wr(3, 20, 3); wr(1, 10, 0); wr(1, 20, 0);
    wr(0, 20, 1);
    offer("R6 single", 20);
    wr(0, 10, 1);
    offer("R6 tie low index", 10);
    wr(3, 30, 1); wr(1, 30, 0); wr(0, 30, 1);
    offer("R8 late arrival", 30);
    ack();
    chk("R7 lower waits", int'(entry_req), 0);
    rd(30, v); chk("R8 taken", v, 'h51);
  endtask

  task automatic t_nest_chain();
    int v;
    wr(3, 31, 1); wr(1, 31, 0); wr(0, 31, 1);
    chk("R7 equal no preempt", int'(entry_req), 0);
    wr(3, 40, 0); wr(1, 40, 0); wr(0, 40, 1);
    offer("R7 preempt", 40);
    ack();
    leave();
    chk("R9 restored level", int'(entry_req), 0);
    rd(40, v); chk("R9 active cleared", v, 'h10);
    leave();
    offer("R10 chain 31", 31);
    ack(); leave();
    offer("R10 chain 10", 10);
    ack(); leave();
    offer("R10 chain 20", 20);
    ack(); leave();
    chk("R10 idle", int'(entry_req), 0);
    rd(20, v); chk("R10 ch20 done", v, 'h13);
  endtask

  task automatic t_empty_exit();
    int v;
    leave();
    chk("R9 empty exit", int'(entry_req), 0);
    wr(3, 3, 15); wr(1, 3, 0); wr(0, 3, 1);
    offer("R9 level intact", 3);
    ack(); leave();
    rd(3, v); chk("R9 ch3", v, 'h1F);
  endtask

  task automatic t_depth();
    int v;
    for (int k = 0; k < 16; k++) begin
      wr(3, k, 15 - k); wr(0, k, 1); wr(1, k, 0);
      offer("R11 nest", k);
      ack();
    end
    rd(15, v); chk("R11 top", v, 'h50);
    wr(1, 14, 0);
    chk("R7 under top", int'(entry_req), 0);
    leave();
    chk("R9 equal after pop", int'(entry_req), 0);
    rd(14, v); chk("R11 ch14 still active", v, 'h71);
    rd(15, v); chk("R11 ch15 left", v, 'h10);
    leave();
    offer("R10 chain in nest", 14);
    ack();
    for (int k = 0; k < 15; k++) leave();
    chk("R11 unwound", int'(entry_req), 0);
    rd(0, v); chk("R11 ch0", v, 'h1F);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_regs();
    t_edge();
    t_set_wins();
    t_arb();
    t_nest_chain();
    t_empty_exit();
    t_depth();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule